// File: doc/BRIEF.md
# Instruction Trace Trap Controller

This block decides, each time an instruction retires, whether the processor must take a trace exception before the next instruction starts. It captures a two-bit trace-control field when an instruction begins. When that instruction retires, it combines the captured field with a change-of-flow flag supplied by the decoder. The flag marks branches, jumps, subroutine calls and returns. A raised trap is held as a pending flag until the exception sequencer acknowledges it.

The block also forms the address from which the trace handler's vector is fetched. That address is a programmable 32-bit vector base plus the trace vector number times four. Each task can therefore point the processor at its own vector table.

The control is a three-state machine:
- **IDLE**: no instruction in flight.
- **EXEC**: an instruction is running and its trace field has been captured.
- **PEND**: a trace trap is waiting for acknowledgement.

Transitions:
- IDLE→EXEC on a begin strobe.
- EXEC→PEND on a retire that qualifies for tracing.
- EXEC→IDLE on a retire that does not qualify and has no begin in the same cycle.
- EXEC→EXEC on a non-qualifying retire that arrives together with a begin.
- PEND→IDLE on acknowledge.

Top module: `trace_trap_ctrl`

## Requirements
- R1: After reset, trace_pend and trace_fire are 0, the base register is 0, and vec_addr reads 36 (vector 9 times 4).
- R2: With the captured field equal to 2'b01 (bit 0 = trace-all), every retire sets trace_pend, whatever cof_flag is.
- R3: With the captured field equal to 2'b10 (bit 1 = trace-flow), a retire sets trace_pend only when cof_flag is 1 in the retire cycle.
- R4: With the captured field equal to 2'b00 or 2'b11 (reserved), a retire never sets trace_pend.
- R5: The field is sampled in the cycle instr_begin is high. Changes to trace_bits while the instruction runs do not affect its decision.
- R6: trace_pend rises in the cycle after the qualifying retire edge and stays high until exc_ack is sampled. trace_fire is high only during the first cycle of trace_pend.
- R7: While trace_pend is high, instr_begin and instr_retire are ignored. After exc_ack the block is IDLE, so a lone retire then raises no trap.
- R8: A write through vbr_wr_en loads vbr_wr_data. From the next cycle, vec_addr equals the written value plus 36, modulo 2^32.
- R9: A retire with no instruction begun (IDLE) raises no trap. A begin arriving in the same cycle as a non-qualifying retire starts the next instruction with the newly sampled field.
- R10: exc_ack while no trap is pending has no effect on later decisions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_begin | input | 1 | Instruction starts; trace field sampled |
| instr_retire | input | 1 | Instruction completes |
| cof_flag | input | 1 | Retiring instruction changes flow |
| trace_bits | input | 2 | Trace control: bit 1 flow-only, bit 0 all |
| exc_ack | input | 1 | Exception sequencer takes the trap |
| vbr_wr_en | input | 1 | Base register write strobe |
| vbr_wr_data | input | 32 | Base register write value |
| trace_pend | output | 1 | Trace trap pending |
| trace_fire | output | 1 | One-cycle pulse when a trap is raised |
| vec_addr | output | 32 | Trace vector fetch address |

## Verification
A wrong captured field or state shows up at the first retire after it. trace_pend is then wrong one clock after that retire edge, so every vector ends with a retire and checks the flag and pulse right there. A state stuck in PEND or EXEC only becomes visible through a later retire, so the directed tests follow each acknowledge or idle retire with one that probes the state. A base-register fault shows on vec_addr one cycle after the write.

// File: rtl/trace_pkg.sv
package trace_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_PEND = 2'd2
    } trc_state_t;

    // bit 1 = flow-only, bit 0 = every instruction
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_ALL  = 2'b01,
        MODE_FLOW = 2'b10,
        MODE_RSVD = 2'b11
    } trc_mode_t;

endpackage

// File: rtl/trace_qualify.sv
module trace_qualify
    import trace_pkg::*;
(
    input  trc_mode_t mode,
    input  logic      cof,
    output logic      hit
);
    always_comb begin
        unique case (mode)
            MODE_OFF:  hit = 1'b0;
            MODE_ALL:  hit = 1'b1;
            MODE_FLOW: hit = cof;
            MODE_RSVD: hit = 1'b0;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/trace_vbr.sv
module trace_vbr #(
    parameter int AW        = 32,
    parameter int TRACE_VEC = 9,
    parameter int ENTRY_SH  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_data,
    output logic [AW-1:0] vec_addr
);
    localparam logic [AW-1:0] VEC_OFS = AW'(TRACE_VEC) << ENTRY_SH;

    logic [AW-1:0] base_q;

    always_ff @(posedge clk) begin
        if (!rst_n)     base_q <= '0;
        else if (wr_en) base_q <= wr_data;
    end

    assign vec_addr = base_q + VEC_OFS;
endmodule

// File: rtl/trace_seq.sv
module trace_seq
    import trace_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       instr_begin,
    input  logic       instr_retire,
    input  logic [1:0] trace_bits,
    input  logic       exc_ack,
    input  logic       hit,
    output trc_mode_t  mode_q,
    output trc_state_t state_q,
    output logic       trace_pend,
    output logic       trace_fire
);
    trc_state_t state_d;
    logic       mode_ld;
    logic       fire_q;

    // next state
    always_comb begin
        state_d = state_q;
        mode_ld = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (instr_begin) begin
                    state_d = ST_EXEC;
                    mode_ld = 1'b1;
                end
            end
            ST_EXEC: begin
                if (instr_retire) begin
                    if (hit) begin
                        state_d = ST_PEND;
                    end else if (instr_begin) begin
                        state_d = ST_EXEC;
                        mode_ld = 1'b1;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_PEND: begin
                if (exc_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_OFF;
        end else begin
            state_q <= state_d;
            if (mode_ld) mode_q <= trc_mode_t'(trace_bits);
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) fire_q <= 1'b0;
        else        fire_q <= (state_q == ST_EXEC) && (state_d == ST_PEND);
    end

    assign trace_pend = (state_q == ST_PEND);
    assign trace_fire = fire_q;
endmodule

// File: rtl/trace_trap_ctrl.sv
module trace_trap_ctrl
    import trace_pkg::*;
#(
    parameter int AW        = 32,
    parameter int TRACE_VEC = 9,
    parameter int ENTRY_SH  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          instr_begin,
    input  logic          instr_retire,
    input  logic          cof_flag,
    input  logic [1:0]    trace_bits,
    input  logic          exc_ack,
    input  logic          vbr_wr_en,
    input  logic [AW-1:0] vbr_wr_data,
    output logic          trace_pend,
    output logic          trace_fire,
    output logic [AW-1:0] vec_addr
);
    trc_mode_t  mode_q;
    trc_state_t state_q;
    logic       hit;

    trace_qualify u_qual (
        .mode (mode_q),
        .cof  (cof_flag),
        .hit  (hit)
    );

    trace_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_begin  (instr_begin),
        .instr_retire (instr_retire),
        .trace_bits   (trace_bits),
        .exc_ack      (exc_ack),
        .hit          (hit),
        .mode_q       (mode_q),
        .state_q      (state_q),
        .trace_pend   (trace_pend),
        .trace_fire   (trace_fire)
    );

    trace_vbr #(.AW(AW), .TRACE_VEC(TRACE_VEC), .ENTRY_SH(ENTRY_SH)) u_vbr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (vbr_wr_en),
        .wr_data  (vbr_wr_data),
        .vec_addr (vec_addr)
    );
endmodule

// File: rtl/trace_trap_chk.sv
module trace_trap_chk
    import trace_pkg::*;
#(
    parameter int AW        = 32,
    parameter int TRACE_VEC = 9,
    parameter int ENTRY_SH  = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          instr_retire,
    input logic          exc_ack,
    input logic          vbr_wr_en,
    input logic [AW-1:0] vbr_wr_data,
    input logic          trace_pend,
    input logic          trace_fire,
    input logic [AW-1:0] vec_addr,
    input trc_mode_t     mode_q,
    input trc_state_t    state_q
);
    localparam logic [AW-1:0] OFS = AW'(TRACE_VEC) << ENTRY_SH;

    // R2
    all_mode_traps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && instr_retire && mode_q == MODE_ALL) |=> trace_fire);

    // R4
    off_mode_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXEC && instr_retire && (mode_q == MODE_OFF || mode_q == MODE_RSVD))
        |=> !trace_fire);

    // R6
    fire_within_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trace_fire |-> trace_pend);

    // R6
    pend_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_pend && !exc_ack) |=> trace_pend);

    // R7
    no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trace_pend |=> !trace_fire);

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trace_pend && exc_ack) |=> !trace_pend);

    // R8
    vbr_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vbr_wr_en |=> vec_addr == $past(vbr_wr_data) + OFS);
endmodule

bind trace_trap_ctrl trace_trap_chk #(.AW(AW), .TRACE_VEC(TRACE_VEC), .ENTRY_SH(ENTRY_SH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .instr_retire (instr_retire),
    .exc_ack      (exc_ack),
    .vbr_wr_en    (vbr_wr_en),
    .vbr_wr_data  (vbr_wr_data),
    .trace_pend   (trace_pend),
    .trace_fire   (trace_fire),
    .vec_addr     (vec_addr),
    .mode_q       (mode_q),
    .state_q      (state_q)
);

// File: tb/trace_trap_ctrl_test.sv
module trace_trap_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        instr_begin, instr_retire, cof_flag, exc_ack, vbr_wr_en;
    logic [1:0]  trace_bits;
    logic [31:0] vbr_wr_data;
    logic        trace_pend, trace_fire;
    logic [31:0] vec_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    trace_trap_ctrl uut (
        .clk(clk), .rst_n(rst_n), .instr_begin(instr_begin), .instr_retire(instr_retire),
        .cof_flag(cof_flag), .trace_bits(trace_bits), .exc_ack(exc_ack),
        .vbr_wr_en(vbr_wr_en), .vbr_wr_data(vbr_wr_data),
        .trace_pend(trace_pend), .trace_fire(trace_fire), .vec_addr(vec_addr)
    );

    // {field at begin[1:0], field while running[1:0], cof, expected trap}
    localparam logic [5:0] VECS [12] = '{
        6'b01_00_0_1, // R2
        6'b01_00_1_1, // R2
        6'b01_10_0_1, // R5
        6'b10_00_1_1, // R3
        6'b10_00_0_0, // R3
        6'b10_01_0_0, // R5
        6'b00_01_1_0, // R4
        6'b00_01_0_0, // R4
        6'b11_01_1_0, // R4
        6'b11_10_1_0, // R4
        6'b00_00_1_0, // R4
        6'b01_11_0_1  // R5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        instr_begin = 0; instr_retire = 0; cof_flag = 0; exc_ack = 0;
        vbr_wr_en = 0; vbr_wr_data = '0; trace_bits = 2'b00;
    endtask

    task automatic run_instr(input logic [1:0] b, input logic [1:0] m, input logic c);
        instr_begin = 1; trace_bits = b;
        tick();
        instr_begin = 0; trace_bits = m; instr_retire = 1; cof_flag = c;
        tick();
        instr_retire = 0; cof_flag = 0;
    endtask

    task automatic ack();
        exc_ack = 1;
        tick();
        exc_ack = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
        tick();
        // R1
        chk("R1 pend", trace_pend, 0);
        chk("R1 fire", trace_fire, 0);
        chk("R1 addr", vec_addr, 32'd36);

        foreach (VECS[i]) begin
            run_instr(VECS[i][5:4], VECS[i][3:2], VECS[i][1]);
            chk($sformatf("R2/R3/R4/R5 vec%0d pend", i), trace_pend, VECS[i][0]);
            chk($sformatf("R6 vec%0d fire", i), trace_fire, VECS[i][0]);
            if (VECS[i][0]) begin
                ack();
                chk($sformatf("R6 vec%0d ack", i), trace_pend, 0);
            end
        end

        // R6: pend held, fire one cycle only
        run_instr(2'b01, 2'b01, 0);
        tick();
        chk("R6 pend held", trace_pend, 1);
        chk("R6 fire single", trace_fire, 0);

        // R7: begin/retire ignored while pending
        run_instr(2'b01, 2'b01, 1);
        chk("R7 pend stays", trace_pend, 1);
        chk("R7 no refire", trace_fire, 0);
        ack();
        chk("R7 ack clears", trace_pend, 0);
        instr_retire = 1; trace_bits = 2'b01;
        tick();
        instr_retire = 0;
        chk("R7 idle after ack", trace_pend, 0);

        // R9: lone retire in IDLE
        instr_retire = 1; cof_flag = 1;
        tick();
        idle_inputs();
        chk("R9 idle retire", trace_pend, 0);

        // R9: back-to-back begin with non-qualifying retire
        instr_begin = 1; trace_bits = 2'b00;
        tick();
        instr_retire = 1; instr_begin = 1; trace_bits = 2'b01;
        tick();
        instr_begin = 0; trace_bits = 2'b00;
        chk("R9 b2b first", trace_pend, 0);
        tick();
        instr_retire = 0;
        chk("R9 b2b second", trace_pend, 1);
        ack();

        // R10: stray ack
        exc_ack = 1;
        tick();
        exc_ack = 0;
        chk("R10 stray ack pend", trace_pend, 0);
        run_instr(2'b10, 2'b10, 1);
        chk("R10 trace after stray", trace_pend, 1);
        ack();

        // R8: base writes
        vbr_wr_en = 1; vbr_wr_data = 32'h0000_1000;
        tick();
        vbr_wr_en = 0;
        chk("R8 addr", vec_addr, 32'h0000_1024);
        vbr_wr_en = 1; vbr_wr_data = 32'hFFFF_FFF0;
        tick();
        vbr_wr_en = 0;
        chk("R8 wrap", vec_addr, 32'h0000_0014);

        // R1: reset clears base and pending
        run_instr(2'b01, 2'b01, 0);
        rst_n = 0;
        tick();
        rst_n = 1;
        tick();
        chk("R1 reset pend", trace_pend, 0);
        chk("R1 reset addr", vec_addr, 32'd36);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule